// File: doc/BRIEF.md
# Two-Level Cycle Current Limiter

This block sits between a switching modulator and the gate driver of a power transistor and protects the transistor cycle by cycle. The modulator raises a gate request for each on-time. The block passes the request to the gate output. While the transistor conducts, it watches two comparator results taken from the switch current sense: a lower limit level and a higher clamp level.

Each on-time opens with a blanking window of a fixed number of clocks. During that window both comparators are ignored, so that the turn-on current spike cannot trip anything. After the window, the two levels have different effects:

- Crossing the limit level ends the current pulse only. The gate stays off until the modulator drops its request.
- Crossing the clamp level ends the pulse and starts a restart lockout. During the lockout every gate request is refused. With a 200 MHz clock the lockout is sized at roughly 1.6 ms.

Both windows are parameters counted in clock cycles.

Top module: `cyc_curr_limiter`

## Requirements
- R1: During the first BLANK_CYCLES clock cycles of every on-time (counted from the first cycle gateOut is high), limitCmp and clampCmp have no effect on gateOut, limitFlag or inhibitFlag.
- R2: When limitCmp is high in a cycle where gateOut is high and blanking is over, gateOut is low after the next rising clock edge and limitFlag is high.
- R3: After a limit trip, gateOut stays low and limitFlag stays high for as long as gateReq stays high. Once gateReq has been low for one cycle, limitFlag is low and a new request turns the gate on normally.
- R4: When clampCmp is high in a cycle where gateOut is high and blanking is over, gateOut is low after the next edge and inhibitFlag is high for exactly INHIBIT_CYCLES consecutive cycles.
- R5: When both comparators are high in the same monitored cycle, the clamp trip wins: inhibitFlag rises and limitFlag stays low.
- R6: While inhibitFlag is high, gateOut is low whatever gateReq does. A request held or raised during the lockout is ignored, and the gate turns on only after gateReq has been seen low after the lockout.
- R7: With no trip pending, gateOut follows gateReq one clock later (a one-cycle registered delay) in both directions.
- R8: While rstN is low, gateOut, limitFlag and inhibitFlag are all low.
- R9: Comparator inputs while gateOut is low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| gateReq | input | 1 | Gate-on request from the modulator |
| limitCmp | input | 1 | Sense above the pulse limit level |
| clampCmp | input | 1 | Sense above the severe clamp level |
| gateOut | output | 1 | Final gate drive signal |
| limitFlag | output | 1 | Current pulse was cut by the limit level |
| inhibitFlag | output | 1 | Restart lockout in progress |

## Verification
The function is exercised with four patterns:

- **Plain requests.** These show the one-cycle follow path.
- **Comparator spikes inside the blanking window and while the gate is off.** These must leave every output untouched.
- **A limit crossing in the first monitored cycle.** This separates an exact blanking length from an off-by-one one. Holding the request afterwards shows that the cut covers only that pulse.
- **A combined limit-and-clamp crossing.** The request is held and also toggled during the lockout. This shows that the clamp wins, that the lockout lasts its full count, and that no request is honoured until it is renewed.

// File: rtl/clim_pkg.sv
package clim_pkg;

  // strobes driven by the control path toward the datapath
  typedef struct packed {
    logic pulseOn;      // gate is currently driven on
    logic loadInhibit;  // start the restart lockout at this edge
  } ctlStrobe_t;

endpackage

// File: rtl/clim_datapath.sv
module clim_datapath
  import clim_pkg::*;
#(
  parameter int BLANK_CYCLES   = 60,
  parameter int INHIBIT_CYCLES = 320000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       limitCmp,
  input  logic       clampCmp,
  output logic       limitHit,
  output logic       clampHit,
  output logic       inhibitOn
);

  localparam int BLANK_W = $clog2(BLANK_CYCLES + 1);
  localparam int INH_W   = $clog2(INHIBIT_CYCLES + 1);
  localparam logic [BLANK_W-1:0] BLANK_END = BLANK_W'(BLANK_CYCLES);
  localparam logic [INH_W-1:0]   INH_LOAD  = INH_W'(INHIBIT_CYCLES);

  logic [BLANK_W-1:0] blankCnt;
  logic [INH_W-1:0]   inhibitCnt;
  logic               monitorOn;

  // counts on-time cycles, saturating at the end of blanking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      blankCnt <= '0;
    else if (!strobe.pulseOn)
      blankCnt <= '0;
    else if (blankCnt != BLANK_END)
      blankCnt <= blankCnt + 1'b1;
  end

  // restart lockout down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      inhibitCnt <= '0;
    else if (strobe.loadInhibit)
      inhibitCnt <= INH_LOAD;
    else if (inhibitCnt != '0)
      inhibitCnt <= inhibitCnt - 1'b1;
  end

  always_comb begin
    monitorOn = strobe.pulseOn && (blankCnt == BLANK_END);
    limitHit  = monitorOn && limitCmp;
    clampHit  = monitorOn && clampCmp;
    inhibitOn = (inhibitCnt != '0);
  end

endmodule

// File: rtl/clim_control.sv
module clim_control
  import clim_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       gateReq,
  input  logic       limitHit,
  input  logic       clampHit,
  input  logic       inhibitOn,
  output ctlStrobe_t strobe,
  output logic       limitFlag
);

  logic pulseQ;
  logic killQ;
  logic limitQ;
  logic tripAny;
  logic limitOnly;

  always_comb begin
    tripAny   = limitHit || clampHit;
    limitOnly = limitHit && !clampHit;   // clamp has priority
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseQ <= 1'b0;
      killQ  <= 1'b0;
      limitQ <= 1'b0;
    end else begin
      pulseQ <= gateReq && !killQ && !inhibitOn && !tripAny;
      // blocks the rest of the current request after a trip or lockout
      if (tripAny || (inhibitOn && gateReq))
        killQ <= 1'b1;
      else if (!gateReq)
        killQ <= 1'b0;
      if (limitOnly)
        limitQ <= 1'b1;
      else if (!gateReq)
        limitQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.pulseOn     = pulseQ;
    strobe.loadInhibit = clampHit;
    limitFlag          = limitQ;
  end

endmodule

// File: rtl/cyc_curr_limiter.sv
module cyc_curr_limiter
  import clim_pkg::*;
#(
  parameter int BLANK_CYCLES   = 60,
  parameter int INHIBIT_CYCLES = 320000
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateReq,
  input  logic limitCmp,
  input  logic clampCmp,
  output logic gateOut,
  output logic limitFlag,
  output logic inhibitFlag
);

  ctlStrobe_t strobe;
  logic       limitHit;
  logic       clampHit;
  logic       inhibitOn;

  clim_control ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .gateReq   (gateReq),
    .limitHit  (limitHit),
    .clampHit  (clampHit),
    .inhibitOn (inhibitOn),
    .strobe    (strobe),
    .limitFlag (limitFlag)
  );

  clim_datapath #(
    .BLANK_CYCLES   (BLANK_CYCLES),
    .INHIBIT_CYCLES (INHIBIT_CYCLES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .limitCmp  (limitCmp),
    .clampCmp  (clampCmp),
    .limitHit  (limitHit),
    .clampHit  (clampHit),
    .inhibitOn (inhibitOn)
  );

  assign gateOut     = strobe.pulseOn;
  assign inhibitFlag = inhibitOn;

endmodule

// File: rtl/clim_checker.sv
module clim_checker #(
  parameter int BLANK_CYCLES   = 60,
  parameter int INHIBIT_CYCLES = 320000
) (
  input logic clk,
  input logic rstN,
  input logic gateReq,
  input logic limitCmp,
  input logic clampCmp,
  input logic gateOut,
  input logic limitFlag,
  input logic inhibitFlag
);

  localparam int ON_W  = $clog2(BLANK_CYCLES + 1);
  localparam int RUN_W = $clog2(INHIBIT_CYCLES + 2);
  localparam logic [ON_W-1:0]  ON_END  = ON_W'(BLANK_CYCLES);
  localparam logic [RUN_W-1:0] RUN_END = RUN_W'(INHIBIT_CYCLES);

  logic [ON_W-1:0]  onCnt;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onCnt  <= '0;
      runLen <= '0;
    end else begin
      if (!gateOut)               onCnt <= '0;
      else if (onCnt != ON_END)   onCnt <= onCnt + 1'b1;
      if (inhibitFlag)            runLen <= runLen + 1'b1;
      else                        runLen <= '0;
    end
  end

  always_comb begin
    if (!rstN) AST_RESET_QUIET: assert (!gateOut && !limitFlag && !inhibitFlag); // R8
  end

  AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (gateOut && onCnt != ON_END && gateReq) |=> gateOut); // R1

  AST_LIMIT_CUTS: assert property (@(posedge clk) disable iff (!rstN)
    (gateOut && onCnt == ON_END && limitCmp) |=> !gateOut); // R2

  AST_LIMIT_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (limitFlag && gateReq) |=> !gateOut); // R3

  AST_CLAMP_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (gateOut && onCnt == ON_END && clampCmp) |=> (inhibitFlag && !gateOut)); // R4

  AST_LOCK_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inhibitFlag) |-> (runLen == RUN_END)); // R4

  AST_CLAMP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (gateOut && onCnt == ON_END && clampCmp && limitCmp) |=> !limitFlag); // R5

  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    inhibitFlag |=> !gateOut); // R6

  AST_GATE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) |-> $past(gateReq)); // R7

  AST_OFF_NO_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    (!gateOut && !inhibitFlag) |=> !$rose(inhibitFlag)); // R9

endmodule

bind cyc_curr_limiter clim_checker #(
  .BLANK_CYCLES   (BLANK_CYCLES),
  .INHIBIT_CYCLES (INHIBIT_CYCLES)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .gateReq     (gateReq),
  .limitCmp    (limitCmp),
  .clampCmp    (clampCmp),
  .gateOut     (gateOut),
  .limitFlag   (limitFlag),
  .inhibitFlag (inhibitFlag)
);

// File: tb/cyc_curr_limiter_tb_top.sv
`timescale 1ns/1ps
module cyc_curr_limiter_tb_top;

  localparam int BLANK   = 6;
  localparam int INHIBIT = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gateReq = 1'b0;
  logic limitCmp = 1'b0;
  logic clampCmp = 1'b0;
  logic gateOut;
  logic limitFlag;
  logic inhibitFlag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cyc_curr_limiter #(
    .BLANK_CYCLES   (BLANK),
    .INHIBIT_CYCLES (INHIBIT)
  ) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .gateReq     (gateReq),
    .limitCmp    (limitCmp),
    .clampCmp    (clampCmp),
    .gateOut     (gateOut),
    .limitFlag   (limitFlag),
    .inhibitFlag (inhibitFlag)
  );

  task automatic check(input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    gateReq = 1'b1; limitCmp = 1'b1; clampCmp = 1'b1;
    waitNeg(3);
    check("R8 gateOut in reset", gateOut, 1'b0);
    check("R8 limitFlag in reset", limitFlag, 1'b0);
    check("R8 inhibitFlag in reset", inhibitFlag, 1'b0);
    gateReq = 1'b0; limitCmp = 1'b0; clampCmp = 1'b0;
    rstN = 1'b1;
    waitNeg(2);
  endtask

  task automatic t_follow;
    gateReq = 1'b1;
    waitNeg(1);
    check("R7 gate on one cycle after request", gateOut, 1'b1);
    waitNeg(3);
    check("R7 gate held while requested", gateOut, 1'b1);
    gateReq = 1'b0;
    waitNeg(1);
    check("R7 gate off one cycle after request drop", gateOut, 1'b0);
    waitNeg(1);
  endtask

  task automatic t_offIgnore;
    limitCmp = 1'b1; clampCmp = 1'b1;
    waitNeg(5);
    check("R9 no lockout while gate off", inhibitFlag, 1'b0);
    check("R9 no limit flag while gate off", limitFlag, 1'b0);
    limitCmp = 1'b0; clampCmp = 1'b0;
    gateReq = 1'b1;
    waitNeg(1);
    check("R9 next request still passes", gateOut, 1'b1);
    gateReq = 1'b0;
    waitNeg(2);
  endtask

  task automatic t_blank;
    logic allOn;
    allOn = 1'b1;
    gateReq = 1'b1;
    waitNeg(1);
    limitCmp = 1'b1; clampCmp = 1'b1;
    for (int i = 0; i < BLANK; i++) begin
      @(negedge clk);
      if (!gateOut || limitFlag || inhibitFlag) allOn = 1'b0;
    end
    limitCmp = 1'b0; clampCmp = 1'b0;
    check("R1 spike in blanking leaves gate and flags", allOn, 1'b1);
    waitNeg(1);
    check("R1 gate still on after blanking spike", gateOut, 1'b1);
    check("R1 no lockout after blanking spike", inhibitFlag, 1'b0);
    gateReq = 1'b0;
    waitNeg(2);
  endtask

  task automatic t_limit;
    logic stayedOff;
    stayedOff = 1'b1;
    gateReq = 1'b1;
    waitNeg(1 + BLANK);
    check("R2 gate on at end of blanking", gateOut, 1'b1);
    limitCmp = 1'b1;
    waitNeg(1);
    check("R2 limit trip cuts gate", gateOut, 1'b0);
    check("R2 limit flag set", limitFlag, 1'b1);
    check("R2 limit trip starts no lockout", inhibitFlag, 1'b0);
    limitCmp = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (gateOut || !limitFlag) stayedOff = 1'b0;
    end
    check("R3 gate stays off within the same request", stayedOff, 1'b1);
    gateReq = 1'b0;
    waitNeg(1);
    check("R3 limit flag cleared after request drop", limitFlag, 1'b0);
    gateReq = 1'b1;
    waitNeg(1);
    check("R3 next request switches normally", gateOut, 1'b1);
    gateReq = 1'b0;
    waitNeg(2);
  endtask

  task automatic t_clamp;
    logic blocked;
    blocked = 1'b1;
    gateReq = 1'b1;
    waitNeg(1 + BLANK);
    limitCmp = 1'b1; clampCmp = 1'b1;
    waitNeg(1);
    check("R4 clamp trip cuts gate", gateOut, 1'b0);
    check("R4 lockout starts", inhibitFlag, 1'b1);
    check("R5 clamp wins over limit", limitFlag, 1'b0);
    limitCmp = 1'b0; clampCmp = 1'b0;
    for (int i = 0; i < INHIBIT - 1; i++) begin
      if (i == 50) gateReq = 1'b0;
      if (i == 51) gateReq = 1'b1;
      @(negedge clk);
      if (gateOut || !inhibitFlag) blocked = 1'b0;
    end
    check("R6 requests refused for whole lockout", blocked, 1'b1);
    check("R4 lockout high in its last cycle", inhibitFlag, 1'b1);
    waitNeg(1);
    check("R4 lockout ends after its full length", inhibitFlag, 1'b0);
    check("R6 held request ignored after lockout", gateOut, 1'b0);
    waitNeg(1);
    check("R6 gate still off without renewed request", gateOut, 1'b0);
    gateReq = 1'b0;
    waitNeg(1);
    gateReq = 1'b1;
    waitNeg(1);
    check("R6 renewed request switches after lockout", gateOut, 1'b1);
    gateReq = 1'b0;
    waitNeg(2);
  endtask

  initial begin
    waitNeg(1);
    t_reset();
    t_follow();
    t_offIgnore();
    t_blank();
    t_limit();
    t_clamp();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule